// File: doc/BRIEF.md
# Low-Address Register Alias Router

This block sits on the path from a load/store issue port. It looks at the address of every request and sends it either to the architectural register file or to the memory system. An address below the register count, which is 0 to 31 for 32 registers, names a register directly: address k selects register k.

Such alias accesses are served entirely through an indexed register-file port. The register number is therefore a run-time value, and software can walk the registers like an array. These accesses never appear on the memory port, so they cause no cache lookup and no translation lookup.

Every other address passes unchanged to the memory port under a valid/ready handshake. The memory response comes back in order, since only one request is in flight at a time. Each accepted request completes with exactly one response pulse, which carries load data and a fault flag.

Top module: `regAliasRouter`

## Requirements
- R1: A request with address below 32 never raises `memReqValid`. It is served through the register-file port, and `reqReady` is high for it whenever the router is idle.
- R2: Address value k selects register k on `rfRdIdx`/`rfWrIdx`. Index 0 is read and written like any other register. Address 32 and higher-order addresses whose low bits are small are not aliased.
- R3: An accepted alias store of full width (`reqSize` = 2, where 0 = byte, 1 = halfword, 2 = word) does the following. It raises `rfWrEn` in the acceptance cycle with `rfWrIdx` equal to the address and `rfWrData` equal to `reqWdata`. One cycle later it gives `respValid` = 1 and `respFault` = 0.
- R4: An accepted full-width alias load gives `respValid` = 1 and `respFault` = 0 one cycle after acceptance. `respRdata` then holds the value of the selected register.
- R5: An alias access with `reqSize` other than 2 raises `respFault` together with `respValid` one cycle after acceptance. It never raises `rfWrEn`, and the register keeps its old value.
- R6: A request with address 32 or above drives `memReqValid` with address, size, store flag and store data unchanged. It is accepted (`reqReady` = 1) in exactly the cycle in which `memReqReady` is 1.
- R7: After a memory request is accepted, the cycle following `memRespValid` gives `respValid` = 1, `respFault` = 0 and `respRdata` equal to the returned `memRespRdata`.
- R8: While a memory request is outstanding, `reqReady` stays low. No new request is forwarded and no register is written, even when the new request is aliased.
- R9: After reset `respValid` is 0, and with an aliased address presented `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Access address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWdata | input | 32 | Store data |
| memReqValid | output | 1 | Forwarded memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqStore | output | 1 | Forwarded store flag |
| memReqAddr | output | 32 | Forwarded address |
| memReqSize | output | 2 | Forwarded size |
| memReqWdata | output | 32 | Forwarded store data |
| memRespValid | input | 1 | Memory response present |
| memRespRdata | input | 32 | Memory response data |
| rfRdIdx | output | 5 | Register-file read index |
| rfRdData | input | 32 | Register-file read data (combinational) |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrIdx | output | 5 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| respValid | output | 1 | Completion pulse |
| respRdata | output | 32 | Load data of the completion |
| respFault | output | 1 | Completion is a rejected partial-width alias access |

## Verification
The assertions assume the memory side is well behaved. `memRespValid` is raised only while a request is outstanding, and only once per request. They also assume the register file's read data reflects `rfRdIdx` within the same cycle.

The bench holds to this with a memory stand-in driven from the test tasks. It returns one response per accepted forwarded request, after a chosen delay, and never otherwise. The register-file stand-in reads combinationally and writes on the clock edge. A request is held stable until it is accepted, as a real issue port would hold it.

// File: rtl/regAliasPkg.sv
package regAliasPkg;
  localparam int SIZE_W = 2;
  localparam logic [SIZE_W-1:0] SIZE_WORD = 2'd2;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctrlStateT;

  // strobes from control to datapath, one per kind of completion
  typedef struct packed {
    logic aliasWr;
    logic aliasRd;
    logic faultHit;
    logic memCapture;
  } strobeT;
endpackage

// File: rtl/regAliasControl.sv
module regAliasControl
  import regAliasPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqStore,
  input  logic   isAlias,
  input  logic   isFullWord,
  input  logic   memReqReady,
  input  logic   memRespValid,
  output logic   reqReady,
  output logic   memReqValid,
  output strobeT strobe
);
  ctrlStateT state, stateNext;
  logic idle;

  assign idle = (state == ST_IDLE);

  always_comb begin
    reqReady    = idle && (isAlias || memReqReady);
    memReqValid = idle && reqValid && !isAlias;
    strobe.aliasWr    = idle && reqValid && isAlias && isFullWord && reqStore;
    strobe.aliasRd    = idle && reqValid && isAlias && isFullWord && !reqStore;
    strobe.faultHit   = idle && reqValid && isAlias && !isFullWord;
    strobe.memCapture = !idle && memRespValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (memReqValid && memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRespValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8: a forwarded request that is taken blocks the next acceptance
  p_wait_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !reqReady);

  // R1: alias requests never go out to memory
  p_alias_stays_local_r1: assert property (@(posedge clk) disable iff (!rstN)
    isAlias |-> !memReqValid);

  // at most one completion kind per cycle
  p_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/regAliasDatapath.sv
module regAliasDatapath
  import regAliasPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [DATA_W-1:0] memRespRdata,
  input  strobeT            strobe,
  output logic              isAlias,
  output logic              isFullWord,
  output logic [IDX_W-1:0]  rfRdIdx,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic              respFault
);
  localparam logic [ADDR_W-1:0] ALIAS_LIMIT = ADDR_W'(REG_COUNT);

  logic [IDX_W-1:0] regIdx;

  assign isAlias    = (reqAddr < ALIAS_LIMIT);
  assign isFullWord = (reqSize == SIZE_WORD);
  assign regIdx     = reqAddr[IDX_W-1:0];

  assign rfRdIdx  = regIdx;
  assign rfWrIdx  = regIdx;
  assign rfWrData = reqWdata;
  assign rfWrEn   = strobe.aliasWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respFault <= 1'b0;
      respRdata <= '0;
    end else begin
      respValid <= strobe.aliasWr || strobe.aliasRd || strobe.faultHit || strobe.memCapture;
      respFault <= strobe.faultHit;
      if (strobe.aliasRd)         respRdata <= rfRdData;
      else if (strobe.memCapture) respRdata <= memRespRdata;
      else                        respRdata <= '0;
    end
  end

  // R4: alias load completes next cycle without fault
  p_alias_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.aliasRd |=> (respValid && !respFault));

  // R5: a write strobe never comes with a partial size
  p_fault_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (reqSize == SIZE_WORD));

  // R7: memory data is returned one cycle later
  p_mem_resp_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memCapture |=> (respValid && !respFault && respRdata == $past(memRespRdata)));
endmodule

// File: rtl/regAliasRouter.sv
module regAliasRouter
  import regAliasPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqStore,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [SIZE_W-1:0] memReqSize,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespRdata,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic              respFault
);
  strobeT strobe;
  logic   isAlias;
  logic   isFullWord;

  // forwarded fields pass through untouched
  assign memReqStore = reqStore;
  assign memReqAddr  = reqAddr;
  assign memReqSize  = reqSize;
  assign memReqWdata = reqWdata;

  regAliasControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqStore     (reqStore),
    .isAlias      (isAlias),
    .isFullWord   (isFullWord),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .strobe       (strobe)
  );

  regAliasDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .reqAddr      (reqAddr),
    .reqSize      (reqSize),
    .reqWdata     (reqWdata),
    .rfRdData     (rfRdData),
    .memRespRdata (memRespRdata),
    .strobe       (strobe),
    .isAlias      (isAlias),
    .isFullWord   (isFullWord),
    .rfRdIdx      (rfRdIdx),
    .rfWrEn       (rfWrEn),
    .rfWrIdx      (rfWrIdx),
    .rfWrData     (rfWrData),
    .respValid    (respValid),
    .respRdata    (respRdata),
    .respFault    (respFault)
  );

  // R2: the register port is indexed by the low address bits of an alias access
  p_index_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (reqAddr == ADDR_W'(rfWrIdx)));

  // R1: forwarded addresses are never in the alias window
  p_mem_outside_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr >= ADDR_W'(REG_COUNT)));
endmodule

// File: tb/regAliasRouter_test.sv
module regAliasRouter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady, reqStore = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqSize = 2'd2;
  logic        memReqValid, memReqReady = 1'b0, memReqStore;
  logic [31:0] memReqAddr, memReqWdata;
  logic [1:0]  memReqSize;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespRdata = '0;
  logic [4:0]  rfRdIdx, rfWrIdx;
  logic [31:0] rfRdData, rfWrData;
  logic        rfWrEn;
  logic        respValid, respFault;
  logic [31:0] respRdata;

  logic [31:0] rfModel [32];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rfRdData = rfModel[rfRdIdx];
  always @(posedge clk) if (rfWrEn) rfModel[rfWrIdx] <= rfWrData;

  regAliasRouter uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic aliasStore(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1; reqStore = 1; reqAddr = addr; reqSize = 2; reqWdata = data;
    #1;
    check("R1 ready", reqReady, 1);
    check("R1 no mem", memReqValid, 0);
    check("R3 wren", rfWrEn, 1);
    check("R2 wridx", rfWrIdx, addr);
    check("R3 wrdata", rfWrData, data);
    @(negedge clk);
    reqValid = 0;
    check("R3 resp", respValid, 1);
    check("R3 fault", respFault, 0);
    check("R3 reg", rfModel[addr], data);
  endtask

  task automatic aliasLoad(input logic [31:0] addr, input logic [31:0] exp);
    @(negedge clk);
    reqValid = 1; reqStore = 0; reqAddr = addr; reqSize = 2;
    #1;
    check("R1 no mem", memReqValid, 0);
    check("R2 rdidx", rfRdIdx, addr);
    @(negedge clk);
    reqValid = 0;
    check("R4 resp", respValid, 1);
    check("R4 fault", respFault, 0);
    check("R4 data", respRdata, exp);
  endtask

  task automatic aliasPartial(input logic [31:0] addr, input logic st, input logic [1:0] sz);
    @(negedge clk);
    reqValid = 1; reqStore = st; reqAddr = addr; reqSize = sz; reqWdata = 32'hBADBAD00;
    #1;
    check("R5 no write", rfWrEn, 0);
    check("R5 no mem", memReqValid, 0);
    @(negedge clk);
    reqValid = 0; reqSize = 2;
    check("R5 resp", respValid, 1);
    check("R5 fault", respFault, 1);
  endtask

  task automatic memAccess(input logic [31:0] addr, input logic st, input logic [1:0] sz,
                           input logic [31:0] wd, input int readyWait, input int respWait,
                           input logic [31:0] rd);
    @(negedge clk);
    reqValid = 1; reqStore = st; reqAddr = addr; reqSize = sz; reqWdata = wd; memReqReady = 0;
    #1;
    check("R6 valid", memReqValid, 1);
    check("R6 addr", memReqAddr, addr);
    check("R6 size", memReqSize, sz);
    check("R6 store", memReqStore, st);
    check("R6 wdata", memReqWdata, wd);
    check("R6 not ready", reqReady, 0);
    check("R2 no rf write", rfWrEn, 0);
    for (int i = 0; i < readyWait; i++) begin
      @(negedge clk); #1;
      check("R6 held", memReqValid, 1);
      check("R6 not ready", reqReady, 0);
    end
    memReqReady = 1;
    #1;
    check("R6 ready follows", reqReady, 1);
    @(negedge clk);
    memReqReady = 0;
    reqValid = 1; reqStore = 1; reqAddr = 7; reqSize = 2; reqWdata = 32'hDEAD0007;
    for (int i = 0; i < respWait; i++) begin
      #1;
      check("R8 ready low", reqReady, 0);
      check("R8 no write", rfWrEn, 0);
      check("R8 no fwd", memReqValid, 0);
      check("R8 no resp", respValid, 0);
      @(negedge clk);
    end
    reqValid = 0;
    memRespValid = 1; memRespRdata = rd;
    @(negedge clk);
    memRespValid = 0;
    check("R7 resp", respValid, 1);
    check("R7 data", respRdata, rd);
    check("R7 fault", respFault, 0);
    check("R8 idle again", reqReady, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rfModel[i] = 32'h1000_0000 + i;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1;
    check("R9 resp", respValid, 0);
    check("R9 ready", reqReady, 1);
    check("R9 mem", memReqValid, 0);

    aliasLoad(4, 32'h1000_0004);
    aliasStore(0, 32'hA0A0_0000);
    aliasLoad(0, 32'hA0A0_0000);
    aliasStore(31, 32'h3131_3131);
    aliasLoad(31, 32'h3131_3131);
    aliasStore(4, 32'h4444_0004);
    aliasStore(5, 32'h5555_0005);
    aliasLoad(4, 32'h4444_0004);
    aliasLoad(5, 32'h5555_0005);

    aliasPartial(9, 1'b1, 2'd0);
    aliasPartial(9, 1'b1, 2'd1);
    aliasPartial(9, 1'b0, 2'd3);
    aliasLoad(9, 32'h1000_0009);

    memAccess(32, 1'b0, 2'd2, 32'h0, 0, 1, 32'hCAFE_0020);
    memAccess(32'h0000_0100, 1'b1, 2'd0, 32'h1234_5678, 2, 3, 32'h0BAD_F00D);
    memAccess(32'hFFFF_FFFC, 1'b0, 2'd1, 32'h0, 1, 2, 32'h7777_8888);
    aliasLoad(7, 32'h1000_0007);
    aliasLoad(0, 32'hA0A0_0000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule